// File: doc/BRIEF.md
# Ground Fault Test Sequencer

This block sequences the output-to-ground fault test of one low-side solenoid channel. The channel is steered by two control lines, A and B. When the controller moves from standby (both lines low) straight to the test code A=0, B=1, the block waits through a qualification delay. It then turns on an external pull-up resistor for a bounded active window. The resulting difference between supply and output is judged once, one clock before that window closes.

The analog pull-up and the comparator sit outside the block. The comparator flag is asynchronous, so the block passes it through a two-flop synchronizer. Every duration is a parameter counted in clock cycles. The defaults are 2 ms of qualification, a 75 ms window and a 10 ms cooldown at a 1 MHz clock. A detected fault is reported to the diagnostic logic and stays up until the controller leaves the test code. A new test cannot start until the cooldown after the previous window has run out. An attempt to start inside the cooldown is refused and flagged for one cycle.

Top module: `gft_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `pullup_en`, `gnd_fault` and `cool_viol` are all 0.
- R2: A test starts only on a clock edge where the code is A=0, B=1 and `chan_idle` was 1 on the previous edge. Entering the test code from any other code (for example from A=1, B=1) never enables the pull-up.
- R3: Once a start has been accepted and the test code is held, `pullup_en` is 1 from the (QUAL_CYC+1)-th rising edge that samples the test code, counting the start edge as the first.
- R4: `pullup_en` stays 1 for exactly ACT_CYC cycles and then returns to 0, even if the test code is still held. It does not rise again until a new start.
- R5: When the window expires, `gnd_fault` becomes 1 in the same cycle that `pullup_en` falls, if and only if the synchronized comparator flag was 1 on the edge one clock before expiry. The synchronized flag is `cmp_gap` delayed by two edges. `gnd_fault` and `pullup_en` are never 1 together.
- R6: A comparator flag that is high earlier in the window but low near its end produces no fault.
- R7: `gnd_fault` holds while the test code is held and drops one cycle after A or B changes.
- R8: Leaving the test code during qualification aborts the test. The pull-up is never enabled and no fault is raised.
- R9: Leaving the test code during the active window drops `pullup_en` one cycle later and raises no fault.
- R10: A start attempt made within COOL_CYC edges after a window ended (by expiry or abort) is refused. `cool_viol` is 1 for exactly one cycle and the pull-up stays off.
- R11: A start attempt made once the cooldown has elapsed runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_a | input | 1 | Synchronized control line A |
| ctl_b | input | 1 | Synchronized control line B |
| chan_idle | input | 1 | Channel is in standby (both control lines low) |
| cmp_gap | input | 1 | Asynchronous comparator flag: supply minus output above the soft-short threshold |
| pullup_en | output | 1 | Enable for the external test pull-up resistor |
| gnd_fault | output | 1 | Ground fault request to the diagnostic logic |
| cool_viol | output | 1 | One-cycle flag for a refused start inside the cooldown |

## Verification
All three outputs are decoded from registers, so each responds to an input change on the first rising edge that samples it. The pull-up rises QUAL_CYC+1 edges after the test code appears, falls ACT_CYC edges later, and a fault appears in that same cycle. A dropped code clears the pull-up or the fault one edge after the change, and a refused start shows `cool_viol` one edge after the attempt. The comparator reaches the decision two edges late, so the bench keeps it stable for many cycles around each decision point. Inputs are driven and outputs sampled on the falling edge. A cycle model in the bench advances once per falling edge, before new inputs are applied, and compares every output in every cycle of both the directed and the random phases.

// File: rtl/gft_pkg.sv
package gft_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_QUAL = 2'd1,
    PH_ACT  = 2'd2,
    PH_HOLD = 2'd3
  } gft_phase_e;
endpackage

// File: rtl/gft_sync.sv
// Two-flop synchronizer, cleared asynchronously.
module gft_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      q  <= 1'b0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gft_down_counter.sv
// Loadable down counter that stops at zero.
module gft_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt;
    if (load) begin
      cnt_en  = 1'b1;
      cnt_nxt = load_val;
    end else if (dec && (cnt != '0)) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/gft_ctrl.sv
// Phase controller: idle -> qualify -> active window -> result hold.
module gft_ctrl
  import gft_pkg::*;
#(
  parameter int QUAL_CYC = 2000,
  parameter int ACT_CYC  = 75000,
  parameter int TW       = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_code,
  input  logic          chan_idle,
  input  logic          cmp_s,
  input  logic [TW-1:0] tmr_cnt,
  input  logic          cool_busy,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          cool_load,
  output logic          pullup_en,
  output logic          gnd_fault,
  output logic          cool_viol
);
  localparam logic [TW-1:0] QUAL_LD = TW'(QUAL_CYC - 1);
  localparam logic [TW-1:0] ACT_LD  = TW'(ACT_CYC - 1);
  localparam logic [TW-1:0] ONE     = TW'(1);

  gft_phase_e phase, phase_nxt;
  logic idle_q;
  logic verdict, verdict_ld;
  logic viol_q, viol_nxt;
  logic start_try;

  assign start_try = (phase == PH_IDLE) && test_code && idle_q;

  always_comb begin
    phase_nxt  = phase;
    tmr_load   = 1'b0;
    tmr_val    = QUAL_LD;
    cool_load  = 1'b0;
    verdict_ld = 1'b0;
    viol_nxt   = start_try && cool_busy;
    case (phase)
      PH_IDLE: begin
        if (start_try && !cool_busy) begin
          phase_nxt = PH_QUAL;
          tmr_load  = 1'b1;
          tmr_val   = QUAL_LD;
        end
      end
      PH_QUAL: begin
        if (!test_code) begin
          phase_nxt = PH_IDLE;
        end else if (tmr_cnt == '0) begin
          phase_nxt = PH_ACT;
          tmr_load  = 1'b1;
          tmr_val   = ACT_LD;
        end
      end
      PH_ACT: begin
        if (!test_code) begin
          phase_nxt = PH_IDLE;
          cool_load = 1'b1;
        end else if (tmr_cnt == '0) begin
          phase_nxt = PH_HOLD;
          cool_load = 1'b1;
        end else if (tmr_cnt == ONE) begin
          verdict_ld = 1'b1;
        end
      end
      PH_HOLD: begin
        if (!test_code) phase_nxt = PH_IDLE;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idle_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      phase  <= phase_nxt;
      idle_q <= chan_idle;
      viol_q <= viol_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          verdict <= 1'b0;
    else if (verdict_ld) verdict <= cmp_s;
  end

  assign pullup_en = (phase == PH_ACT);
  assign gnd_fault = (phase == PH_HOLD) && verdict;
  assign cool_viol = viol_q;
endmodule

// File: rtl/gft_sequencer.sv
// Ground fault test sequencer for one solenoid channel.
module gft_sequencer #(
  parameter int QUAL_CYC = 2000,
  parameter int ACT_CYC  = 75000,
  parameter int COOL_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_a,
  input  logic ctl_b,
  input  logic chan_idle,
  input  logic cmp_gap,
  output logic pullup_en,
  output logic gnd_fault,
  output logic cool_viol
);
  localparam int TMAX = (QUAL_CYC > ACT_CYC) ? QUAL_CYC : ACT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int CW   = $clog2(COOL_CYC + 1);
  localparam logic [CW-1:0] COOL_LD = CW'(COOL_CYC);

  logic          rst_sn;
  logic          cmp_s;
  logic          test_code;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic [TW-1:0] tmr_cnt;
  logic          cool_load;
  logic [CW-1:0] cool_cnt;
  logic          cool_busy;

  gft_sync u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  gft_sync u_cmp_sync (
    .clk(clk), .rst_n(rst_sn), .d(cmp_gap), .q(cmp_s)
  );

  assign test_code = !ctl_a && ctl_b;
  assign cool_busy = (cool_cnt != '0);

  gft_down_counter #(.W(TW)) u_phase_tmr (
    .clk(clk), .rst_n(rst_sn), .load(tmr_load), .load_val(tmr_val),
    .dec(1'b1), .cnt(tmr_cnt)
  );

  gft_down_counter #(.W(CW)) u_cool_tmr (
    .clk(clk), .rst_n(rst_sn), .load(cool_load), .load_val(COOL_LD),
    .dec(1'b1), .cnt(cool_cnt)
  );

  gft_ctrl #(.QUAL_CYC(QUAL_CYC), .ACT_CYC(ACT_CYC), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .test_code(test_code), .chan_idle(chan_idle),
    .cmp_s(cmp_s), .tmr_cnt(tmr_cnt), .cool_busy(cool_busy),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .cool_load(cool_load),
    .pullup_en(pullup_en), .gnd_fault(gnd_fault), .cool_viol(cool_viol)
  );
endmodule

// File: rtl/gft_sequencer_chk.sv
// Property checker, bound to the top module.
module gft_sequencer_chk #(
  parameter int ACT_CYC = 75000
) (
  input logic clk,
  input logic rst_n,
  input logic ctl_a,
  input logic ctl_b,
  input logic pullup_en,
  input logic gnd_fault,
  input logic cool_viol
);
  localparam int RW = $clog2(ACT_CYC + 2);
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [RW-1:0] pu_run;
  logic          code_now;

  assign code_now = !ctl_a && ctl_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pu_run <= '0;
    else if (!pullup_en)                pu_run <= '0;
    else if (pu_run != RMAX)            pu_run <= pu_run + 1'b1;
  end

  AST_PU_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pullup_en) |-> $past(code_now)); // R3
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pu_run <= RW'(ACT_CYC)); // R4
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pullup_en && gnd_fault)); // R5
  AST_FAULT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnd_fault && !code_now) |=> !gnd_fault); // R7
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en && !code_now) |=> !pullup_en); // R9
  AST_VIOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cool_viol |=> !cool_viol); // R10
  AST_VIOL_NO_PU: assert property (@(posedge clk) disable iff (!rst_n)
    cool_viol |-> !pullup_en); // R10
endmodule

bind gft_sequencer gft_sequencer_chk #(.ACT_CYC(ACT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .ctl_b(ctl_b),
  .pullup_en(pullup_en), .gnd_fault(gnd_fault), .cool_viol(cool_viol)
);

// File: tb/gft_sequencer_test.sv
module gft_sequencer_test;
  localparam int QC = 8;
  localparam int AC = 20;
  localparam int CC = 30;

  logic clk = 1'b0;
  logic rst_n, ctl_a, ctl_b, chan_idle, cmp_gap;
  logic pullup_en, gnd_fault, cool_viol;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit model_on = 0;

  // cycle model state
  int m_ph, m_el, m_cool;
  bit m_verd, m_psb, m_c1, m_c2, m_viol;

  always #10 clk = ~clk;

  gft_sequencer #(.QUAL_CYC(QC), .ACT_CYC(AC), .COOL_CYC(CC)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .chan_idle(chan_idle), .cmp_gap(cmp_gap), .pullup_en(pullup_en),
    .gnd_fault(gnd_fault), .cool_viol(cool_viol)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_pu();    return m_ph == 2;           endfunction
  function automatic bit exp_fault(); return m_ph == 3 && m_verd; endfunction

  task automatic model_step();
    bit tc;
    bit set_cool;
    tc = !ctl_a && ctl_b;
    set_cool = 0;
    m_viol = 0;
    case (m_ph)
      0: if (tc && m_psb) begin
           if (m_cool > 0) m_viol = 1;
           else begin m_ph = 1; m_el = 0; end
         end
      1: if (!tc) m_ph = 0;
         else if (m_el == QC - 1) begin m_ph = 2; m_el = 0; end
         else m_el++;
      2: if (!tc) begin m_ph = 0; set_cool = 1; end
         else begin
           if (m_el == AC - 2) m_verd = m_c2;
           if (m_el == AC - 1) begin m_ph = 3; set_cool = 1; end
           else m_el++;
         end
      default: if (!tc) m_ph = 0;
    endcase
    if (set_cool) m_cool = CC;
    else if (m_cool > 0) m_cool--;
    m_c2 = m_c1;
    m_c1 = cmp_gap;
    m_psb = chan_idle;
  endtask

  // one cycle: advance model, compare, return so caller may drive
  task automatic tick();
    @(negedge clk);
    if (model_on) begin
      model_step();
      check("R4 pullup model", pullup_en, exp_pu());
      check("R5 fault model", gnd_fault, exp_fault());
      check("R10 viol model", cool_viol, m_viol);
    end
  endtask

  task automatic set_code(bit a, bit b);
    ctl_a = a; ctl_b = b; chan_idle = !a && !b;
  endtask

  task automatic wait_cool();
    set_code(0, 0);
    repeat (CC + 3) tick();
  endtask

  // start a test, return cycles until pull-up seen
  task automatic run_to_pullup(output int n);
    set_code(0, 1);
    n = 0;
    do begin tick(); n++; end while (!pullup_en && n < QC + 10);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    rst_n = 0; cmp_gap = 0; set_code(0, 0);
    repeat (3) @(negedge clk);
    check("R1 pullup in reset", pullup_en, 1'b0);
    check("R1 fault in reset", gnd_fault, 1'b0);
    check("R1 viol in reset", cool_viol, 1'b0);
    rst_n = 1;
    repeat (5) tick();
    check("R1 pullup after reset", pullup_en, 1'b0);
    m_ph = 0; m_el = 0; m_cool = 0; m_verd = 0;
    m_psb = 1; m_c1 = 0; m_c2 = 0; m_viol = 0;
    model_on = 1;

    // normal test with fault present
    cmp_gap = 1;
    run_to_pullup(n);
    check("R3 qualification delay", n == QC + 1, 1'b1);
    n = 0;
    while (pullup_en && n < AC + 5) begin tick(); n++; end
    check("R4 window length", n == AC, 1'b1);
    check("R5 fault at expiry", gnd_fault, 1'b1);
    repeat (10) tick();
    check("R7 fault held", gnd_fault, 1'b1);
    check("R4 no re-enable", pullup_en, 1'b0);
    set_code(0, 0);
    tick();
    check("R7 fault released", gnd_fault, 1'b0);

    // restart inside cooldown
    set_code(0, 1);
    tick();
    check("R10 viol pulse", cool_viol, 1'b1);
    tick();
    check("R10 viol one cycle", cool_viol, 1'b0);
    repeat (QC + 4) tick();
    check("R10 pullup refused", pullup_en, 1'b0);

    // after cooldown, no fault
    cmp_gap = 0;
    wait_cool();
    run_to_pullup(n);
    check("R11 start after cooldown", n == QC + 1, 1'b1);
    repeat (AC) tick();
    check("R5 no fault when clear", gnd_fault, 1'b0);
    check("R4 window over", pullup_en, 1'b0);

    // comparator high early, low at end
    wait_cool();
    cmp_gap = 1;
    run_to_pullup(n);
    repeat (AC / 2) tick();
    cmp_gap = 0;
    repeat (AC) tick();
    check("R6 early flag ignored", gnd_fault, 1'b0);

    // abort in qualification
    wait_cool();
    cmp_gap = 1;
    set_code(0, 1);
    repeat (3) tick();
    set_code(1, 1);
    n = 0;
    repeat (QC + 3) begin tick(); if (pullup_en) n++; end
    check("R8 qual abort no pullup", n == 0, 1'b1);
    check("R8 qual abort no fault", gnd_fault, 1'b0);

    // abort in active window
    wait_cool();
    run_to_pullup(n);
    repeat (5) tick();
    set_code(0, 0);
    tick();
    check("R9 pullup dropped", pullup_en, 1'b0);
    check("R9 no fault", gnd_fault, 1'b0);

    // entry from excitation code is not a start
    wait_cool();
    set_code(1, 1);
    repeat (3) tick();
    set_code(0, 1);
    n = 0;
    repeat (QC + 5) begin tick(); if (pullup_en) n++; end
    check("R2 no start from non-idle", n == 0, 1'b1);

    // constrained random phase against the model
    set_code(0, 0);
    for (int i = 0; i < 4000; i++) begin
      tick();
      if ($urandom_range(0, 99) < 4) begin
        int c = $urandom_range(0, 9);
        if (c < 4)      set_code(0, 0);
        else if (c < 8) set_code(0, 1);
        else if (c < 9) set_code(1, 1);
        else            set_code(1, 0);
      end
      if ($urandom_range(0, 99) < 2) cmp_gap = ~cmp_gap;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule